// File: doc/BRIEF.md
# Frame-Based Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel. Software sets up a block transfer through a small word-addressed register port. It loads a source and a destination start address, an element size, an element count per frame, a frame count and one addressing rule for each side. Setting the enable bit starts the copy. For every element the engine reads once from the source and then writes once to the destination, over a single valid/ready memory port.

When the last element of the last frame has been written, the engine drops its own enable bit and raises a completion flag. That flag drives the interrupt line only when the matching enable bit is set. Software acknowledges the event by writing a one to the flag bit. While a block runs, read-only registers show the current source and destination addresses and the element and frame positions.

Top module: `dma_frame_chan`

## Requirements
- R1: Register word offsets on `reg_addr`: 0 CTL, 1 EVT_EN, 2 EVT_FLAG, 3 SRC_BASE, 4 DST_BASE, 5 ELEMS, 6 FRAMES, 7 SRC_NOW, 8 DST_NOW, 9 ELEM_POS, 10 FRAME_POS. After reset every register reads 0, and `mem_valid` and `irq` are low.
- R2: CTL[17:16] selects the element size: 0 is byte, 1 is halfword, 2 is word, and 3 is treated as word. `mem_size` carries the effective code. Each write puts the element read from the source into the low bytes of `mem_wdata` with the upper bits zero, so memory stores exactly the element bytes.
- R3: Per element the engine issues one read at the current source address, then one write at the current destination address. A block moves ELEMS × FRAMES elements, frame after frame.
- R4: CTL[13:12] is the source mode and CTL[15:14] is the destination mode. Code 2'b01 advances that address by 1 << size after each element. Code 2'b00 keeps the address constant, and so do codes 2'b10 and 2'b11.
- R5: An ELEMS or FRAMES value of 0 at start is treated as 1.
- R6: CTL bit 7 is the enable. Setting it while the engine is idle starts a block. After the last write of the block, the enable bit reads 0 and EVT_FLAG bit 5 reads 1.
- R7: `irq` is high exactly when EVT_FLAG bit 5 and EVT_EN bit 5 are both 1.
- R8: Writing EVT_FLAG with bit 5 set clears the flag. Writing it with bit 5 clear leaves the flag unchanged.
- R9: While the enable bit is 1, writes to SRC_BASE, DST_BASE, ELEMS, FRAMES and the CTL mode and size fields are ignored.
- R10: At completion, SRC_NOW and DST_NOW hold the start address plus the total element count × step for incrementing sides, or the start address for constant sides. ELEM_POS reads 0 and FRAME_POS reads the effective frame count.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` hold steady. Clearing the enable during a block lets the outstanding request complete, then stops the engine without setting EVT_FLAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_size | output | 2 | Effective element size code |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data, element in the low bytes |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Read data, element in the low bytes |
| irq | output | 1 | Block-complete interrupt |

## Verification
A wrong step or a wrong mode decode sends a write to a wrong address within one element pair, so memory diverges from the reference copy early. It also shows in SRC_NOW/DST_NOW at completion. An off-by-one in the element or frame counters leaves one element too few or one too many in the destination. It also shifts FRAME_POS and the final addresses, which can be read as soon as the flag rises. A request dropped under backpressure, or a flag that is set or cleared wrongly, appears at the memory port or on `irq` within the cycle after the offending edge.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} dma_state_e;

  localparam logic [1:0] MODE_CONST = 2'b00;
  localparam logic [1:0] MODE_INC   = 2'b01;

  localparam logic [3:0] REG_CTL       = 4'd0;
  localparam logic [3:0] REG_EVT_EN    = 4'd1;
  localparam logic [3:0] REG_EVT_FLAG  = 4'd2;
  localparam logic [3:0] REG_SRC_BASE  = 4'd3;
  localparam logic [3:0] REG_DST_BASE  = 4'd4;
  localparam logic [3:0] REG_ELEMS     = 4'd5;
  localparam logic [3:0] REG_FRAMES    = 4'd6;
  localparam logic [3:0] REG_SRC_NOW   = 4'd7;
  localparam logic [3:0] REG_DST_NOW   = 4'd8;
  localparam logic [3:0] REG_ELEM_POS  = 4'd9;
  localparam logic [3:0] REG_FRAME_POS = 4'd10;

  localparam int CTL_EN_BIT    = 7;
  localparam int CTL_SMODE_LSB = 12;
  localparam int CTL_DMODE_LSB = 14;
  localparam int CTL_SIZE_LSB  = 16;
  localparam int EVT_BLOCK_BIT = 5;

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              step,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] cur
);

  logic [ADDR_W-1:0] cur_q, cur_d, incr;

  assign incr = (mode == MODE_INC) ? (ADDR_W'(1) << size) : '0;

  always_comb begin
    cur_d = cur_q;
    if (load)      cur_d = start_addr;
    else if (step) cur_d = cur_q + incr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cur_q <= '0;
    else if (load || step)  cur_q <= cur_d;
  end

  assign cur = cur_q;

  // R4
  const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode != MODE_INC) |=> $stable(cur_q));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode == MODE_INC) |=> cur_q == $past(cur_q) + (ADDR_W'(1) << $past(size)));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] elems,
  input  logic [CNT_W-1:0] frames,
  input  logic             mem_ready,
  output logic             mem_valid,
  output logic             mem_we,
  output logic             load,
  output logic             step,
  output logic             rd_hs,
  output logic             blk_done,
  output logic [CNT_W-1:0] elem_pos,
  output logic [CNT_W-1:0] frame_pos
);

  dma_state_e       state_q, state_d;
  logic [CNT_W-1:0] e_q, e_d, f_q, f_d;
  logic [CNT_W-1:0] e_last, f_last;

  assign e_last = (elems  == '0) ? '0 : elems  - 1'b1;
  assign f_last = (frames == '0) ? '0 : frames - 1'b1;

  always_comb begin
    state_d  = state_q;
    e_d      = e_q;
    f_d      = f_q;
    load     = 1'b0;
    step     = 1'b0;
    rd_hs    = 1'b0;
    blk_done = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          load    = 1'b1;
          e_d     = '0;
          f_d     = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ready) begin
          rd_hs   = 1'b1;
          state_d = en ? ST_WRITE : ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (mem_ready) begin
          step = 1'b1;
          if (e_q == e_last) begin
            e_d = '0;
            f_d = f_q + 1'b1;
            if (f_q == f_last) begin
              blk_done = 1'b1;
              state_d  = ST_IDLE;
            end else begin
              state_d = en ? ST_READ : ST_IDLE;
            end
          end else begin
            e_d     = e_q + 1'b1;
            state_d = en ? ST_READ : ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      e_q     <= '0;
      f_q     <= '0;
    end else begin
      state_q <= state_d;
      if (load || step) begin
        e_q <= e_d;
        f_q <= f_d;
      end
    end
  end

  assign mem_valid = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WRITE);
  assign elem_pos  = e_q;
  assign frame_pos = f_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (state_q == ST_IDLE));

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(rd_hs));

  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (e_q <= e_last && f_q <= f_last));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              blk_done,
  input  logic [ADDR_W-1:0] src_now,
  input  logic [ADDR_W-1:0] dst_now,
  input  logic [CNT_W-1:0]  elem_pos,
  input  logic [CNT_W-1:0]  frame_pos,
  output logic              en,
  output logic [1:0]        smode,
  output logic [1:0]        dmode,
  output logic [1:0]        size,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [CNT_W-1:0]  elems,
  output logic [CNT_W-1:0]  frames,
  output logic              irq
);

  logic              en_q, en_d, ie_q, ie_d, flag_q, flag_d;
  logic [1:0]        sm_q, sm_d, dm_q, dm_d, sz_q, sz_d;
  logic [ADDR_W-1:0] sb_q, sb_d, db_q, db_d;
  logic [CNT_W-1:0]  ec_q, ec_d, fc_q, fc_d;

  always_comb begin
    en_d = en_q; ie_d = ie_q; flag_d = flag_q;
    sm_d = sm_q; dm_d = dm_q; sz_d = sz_q;
    sb_d = sb_q; db_d = db_q; ec_d = ec_q; fc_d = fc_q;
    if (reg_we) begin
      case (reg_addr)
        REG_CTL: begin
          en_d = reg_wdata[CTL_EN_BIT];
          if (!en_q) begin
            sm_d = reg_wdata[CTL_SMODE_LSB +: 2];
            dm_d = reg_wdata[CTL_DMODE_LSB +: 2];
            sz_d = reg_wdata[CTL_SIZE_LSB  +: 2];
          end
        end
        REG_EVT_EN:   ie_d = reg_wdata[EVT_BLOCK_BIT];
        REG_EVT_FLAG: if (reg_wdata[EVT_BLOCK_BIT]) flag_d = 1'b0;
        REG_SRC_BASE: if (!en_q) sb_d = reg_wdata[ADDR_W-1:0];
        REG_DST_BASE: if (!en_q) db_d = reg_wdata[ADDR_W-1:0];
        REG_ELEMS:    if (!en_q) ec_d = reg_wdata[CNT_W-1:0];
        REG_FRAMES:   if (!en_q) fc_d = reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
    if (blk_done) begin
      en_d   = 1'b0;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; flag_q <= 1'b0;
      sm_q <= '0; dm_q <= '0; sz_q <= '0;
      sb_q <= '0; db_q <= '0; ec_q <= '0; fc_q <= '0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      sm_q   <= sm_d;
      dm_q   <= dm_d;
      sz_q   <= sz_d;
      sb_q   <= sb_d;
      db_q   <= db_d;
      ec_q   <= ec_d;
      fc_q   <= fc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTL: begin
        reg_rdata[CTL_EN_BIT]           = en_q;
        reg_rdata[CTL_SMODE_LSB +: 2]   = sm_q;
        reg_rdata[CTL_DMODE_LSB +: 2]   = dm_q;
        reg_rdata[CTL_SIZE_LSB  +: 2]   = sz_q;
      end
      REG_EVT_EN:    reg_rdata[EVT_BLOCK_BIT] = ie_q;
      REG_EVT_FLAG:  reg_rdata[EVT_BLOCK_BIT] = flag_q;
      REG_SRC_BASE:  reg_rdata = 32'(sb_q);
      REG_DST_BASE:  reg_rdata = 32'(db_q);
      REG_ELEMS:     reg_rdata = 32'(ec_q);
      REG_FRAMES:    reg_rdata = 32'(fc_q);
      REG_SRC_NOW:   reg_rdata = 32'(src_now);
      REG_DST_NOW:   reg_rdata = 32'(dst_now);
      REG_ELEM_POS:  reg_rdata = 32'(elem_pos);
      REG_FRAME_POS: reg_rdata = 32'(frame_pos);
      default: ;
    endcase
  end

  assign en       = en_q;
  assign smode    = sm_q;
  assign dmode    = dm_q;
  assign size     = (sz_q == 2'd3) ? 2'd2 : sz_q;
  assign src_base = sb_q;
  assign dst_base = db_q;
  assign elems    = ec_q;
  assign frames   = fc_q;
  assign irq      = flag_q & ie_q;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (flag_q && !en_q));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == REG_EVT_FLAG && reg_wdata[EVT_BLOCK_BIT] && !blk_done) |=> !flag_q);

  // R9
  base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && reg_we && reg_addr == REG_SRC_BASE) |=> $stable(sb_q));

endmodule

// File: rtl/dma_frame_chan.sv
module dma_frame_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);

  localparam int SIDES = 2;

  logic              en, load, step, rd_hs, blk_done;
  logic [1:0]        smode, dmode, size;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [CNT_W-1:0]  elems, frames, elem_pos, frame_pos;
  logic [ADDR_W-1:0] side_base [SIDES];
  logic [1:0]        side_mode [SIDES];
  logic [ADDR_W-1:0] side_cur  [SIDES];
  logic [31:0]       data_q, data_d;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_done(blk_done),
    .src_now(side_cur[0]), .dst_now(side_cur[1]),
    .elem_pos(elem_pos), .frame_pos(frame_pos),
    .en(en), .smode(smode), .dmode(dmode), .size(size),
    .src_base(src_base), .dst_base(dst_base), .elems(elems), .frames(frames),
    .irq(irq)
  );

  dma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .elems(elems), .frames(frames),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .load(load), .step(step), .rd_hs(rd_hs), .blk_done(blk_done),
    .elem_pos(elem_pos), .frame_pos(frame_pos)
  );

  assign side_base[0] = src_base;
  assign side_base[1] = dst_base;
  assign side_mode[0] = smode;
  assign side_mode[1] = dmode;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_addr_gen #(.ADDR_W(ADDR_W)) u_ag (
      .clk(clk), .rst_n(rst_n), .load(load), .start_addr(side_base[s]),
      .step(step), .mode(side_mode[s]), .size(size), .cur(side_cur[s])
    );
  end

  always_comb begin
    case (size)
      2'd0:    data_d = {24'b0, mem_rdata[7:0]};
      2'd1:    data_d = {16'b0, mem_rdata[15:0]};
      default: data_d = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (rd_hs) data_q <= data_d;
  end

  assign mem_addr  = mem_we ? side_cur[1] : side_cur[0];
  assign mem_wdata = data_q;
  assign mem_size  = size;

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr));

endmodule

// File: tb/dma_frame_chan_test.sv
module dma_frame_chan_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  typedef struct packed {
    logic [7:0] src;
    logic [7:0] dst;
    logic [1:0] size;
    logic [7:0] ecnt;
    logic [7:0] fcnt;
    logic [1:0] smode;
    logic [1:0] dmode;
    logic       ie;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{8'h00, 8'h80, 2'd2, 8'd4, 8'd2, 2'b01, 2'b01, 1'b1},
    '{8'h20, 8'hA0, 2'd0, 8'd3, 8'd3, 2'b01, 2'b01, 1'b0},
    '{8'h30, 8'hB0, 2'd1, 8'd5, 8'd1, 2'b00, 2'b01, 1'b1},
    '{8'h40, 8'hC0, 2'd2, 8'd2, 8'd3, 2'b01, 2'b00, 1'b1},
    '{8'h5A, 8'hC8, 2'd0, 8'd0, 8'd0, 2'b01, 2'b01, 1'b0},
    '{8'h62, 8'hCA, 2'd1, 8'd2, 8'd2, 2'b00, 2'b00, 1'b1},
    '{8'h70, 8'hD0, 2'd3, 8'd2, 8'd1, 2'b01, 2'b10, 1'b1}
  };

  logic        clk, rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_valid, mem_we, mem_ready, irq;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0]  mem     [256];
  logic [7:0]  ref_mem [256];
  int          n_chk, n_fail, n_rd, n_wr, hold_err, stall_cnt;
  logic        pend;
  logic [31:0] pend_addr;
  logic        pend_we;

  dma_frame_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                      mem[8'(mem_addr + 1)], mem[mem_addr[7:0]]};

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        n_wr <= n_wr + 1;
        for (int b = 0; b < (1 << mem_size); b++)
          mem[8'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
      end else begin
        n_rd <= n_rd + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (pend && (!mem_valid || mem_addr != pend_addr || mem_we != pend_we))
      hold_err <= hold_err + 1;
    stall_cnt <= stall_cnt + 1;
    mem_ready <= mem_valid && (stall_cnt % 3 != 1);
    pend      <= mem_valid && !(mem_valid && (stall_cnt % 3 != 1));
    pend_addr <= mem_addr;
    pend_we   <= mem_we;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_flag(output logic ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 5000 && !ok; i++) begin
      rd(4'd2, v);
      ok = v[5];
    end
  endtask

  function automatic logic [31:0] ctl_word(input logic en, input logic [1:0] sm,
                                           input logic [1:0] dm, input logic [1:0] sz);
    logic [31:0] w;
    w = '0;
    w[7] = en; w[13:12] = sm; w[15:14] = dm; w[17:16] = sz;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        ok;
    int          mism, ne, nf, step, sz, tot;
    logic [31:0] sa, da;
    n_chk = 0; n_fail = 0; n_rd = 0; n_wr = 0; hold_err = 0; stall_cnt = 0;
    pend = 1'b0; pend_addr = '0; pend_we = 1'b0; mem_ready = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 mem_valid after reset", 32'(mem_valid), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // Table of vectors
    for (int k = 0; k < NVEC; k++) begin
      sz   = (VEC[k].size == 2'd3) ? 2 : int'(VEC[k].size);
      step = 1 << sz;
      ne   = (VEC[k].ecnt == 0) ? 1 : int'(VEC[k].ecnt);
      nf   = (VEC[k].fcnt == 0) ? 1 : int'(VEC[k].fcnt);
      tot  = ne * nf;
      sa   = 32'(VEC[k].src);
      da   = 32'(VEC[k].dst);
      for (int e = 0; e < tot; e++) begin
        logic [7:0] bytes [4];
        for (int b = 0; b < step; b++) bytes[b] = ref_mem[8'(sa + 32'(b))];
        for (int b = 0; b < step; b++) ref_mem[8'(da + 32'(b))] = bytes[b];
        if (VEC[k].smode == 2'b01) sa = sa + 32'(step);
        if (VEC[k].dmode == 2'b01) da = da + 32'(step);
      end
      wr(4'd3, 32'(VEC[k].src));
      wr(4'd4, 32'(VEC[k].dst));
      wr(4'd5, 32'(VEC[k].ecnt));
      wr(4'd6, 32'(VEC[k].fcnt));
      wr(4'd1, 32'(VEC[k].ie) << 5);
      wr(4'd0, ctl_word(1'b1, VEC[k].smode, VEC[k].dmode, VEC[k].size));
      wait_flag(ok);
      chk("R6 block flag set", 32'(ok), 32'h1);
      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mism++;
      chk("R3 R2 R4 R5 memory image mismatches", 32'(mism), 32'h0);
      chk("R2 mem_size code", 32'(mem_size), 32'(sz));
      chk("R7 irq level", 32'(irq), 32'(VEC[k].ie));
      rd(4'd0, v);
      chk("R6 enable self-cleared", 32'(v[7]), 32'h0);
      rd(4'd7, v);
      chk("R10 R4 SRC_NOW", v, sa);
      rd(4'd8, v);
      chk("R10 R4 DST_NOW", v, da);
      rd(4'd9, v);
      chk("R10 ELEM_POS", v, 32'h0);
      rd(4'd10, v);
      chk("R10 R5 FRAME_POS", v, 32'(nf));
      wr(4'd2, 32'h0);
      rd(4'd2, v);
      chk("R8 zero write keeps flag", 32'(v[5]), 32'h1);
      wr(4'd2, 32'h20);
      rd(4'd2, v);
      chk("R8 one write clears flag", 32'(v[5]), 32'h0);
      chk("R7 irq low after clear", 32'(irq), 32'h0);
    end

    // R9 lock while enabled, R11 abort
    wr(4'd3, 32'h00);
    wr(4'd4, 32'h80);
    wr(4'd5, 32'd8);
    wr(4'd6, 32'd4);
    wr(4'd1, 32'h20);
    n_rd = 0; n_wr = 0;
    wr(4'd0, ctl_word(1'b1, 2'b01, 2'b01, 2'd2));
    repeat (6) @(negedge clk);
    wr(4'd3, 32'h55);
    rd(4'd3, v);
    chk("R9 SRC_BASE locked", v, 32'h0);
    wr(4'd5, 32'd3);
    rd(4'd5, v);
    chk("R9 ELEMS locked", v, 32'd8);
    wr(4'd0, ctl_word(1'b1, 2'b00, 2'b10, 2'd0));
    rd(4'd0, v);
    chk("R9 CTL fields locked", v, ctl_word(1'b1, 2'b01, 2'b01, 2'd2));
    wr(4'd0, 32'h0);
    repeat (8) @(negedge clk);
    chk("R11 engine stopped", 32'(mem_valid), 32'h0);
    rd(4'd2, v);
    chk("R11 no flag on abort", 32'(v[5]), 32'h0);
    chk("R11 no irq on abort", 32'(irq), 32'h0);
    chk("R11 partial block", 32'(n_wr < 32), 32'h1);
    chk("R11 R3 read/write pairing", 32'((n_rd == n_wr) || (n_rd == n_wr + 1)), 32'h1);
    chk("R11 request held under backpressure", 32'(hold_err), 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule